// File: doc/BRIEF.md
# Pulse-Triggered Register Frame Sequencer

This block plays back register settings that were prepared in advance in an external SRAM. The SRAM holds blocks of equal-sized frames. Each frame is a list of entries, and each entry pairs an 8-bit target register number with a data byte. A rising edge on the start input fetches the next frame from the SRAM. The block places every entry of that frame into a bank of 256 byte-wide holding registers. A commit then copies the whole holding bank into the active bank in a single clock edge, so the order of entries inside a frame does not matter.

A CPU sets up the playback through a small set of indexed control registers:

| Index | Register | Contents |
|---|---|---|
| 1 | Commit mode | Bit 0 selects automatic or pulse-driven commit |
| 2 | Frame size | Number of entries per frame |
| 4 | Scan count | Number of frames still to play |
| 8 | Block start | SRAM address of the first frame in the block |

The SRAM address of the current frame is computed from the block start, the frame size and a running frame index. Entries are fetched at a fixed pace of several clock cycles each, followed by a short closing interval per frame. With a 100 MHz clock this gives 80 ns per entry and 20 ns of closing time per frame.

Top module: `frame_replay_seq`

## Requirements
- R1: The frame size register (index 2) holds values from 1 to 255. A write of 0 stores 1, and a write above 255 stores 255.
- R2: A frame starts at SRAM address block start + frame size × frame index, where the block start is set through index 8. Writing the block start clears the frame index to zero. The index increases by one after each completed frame.
- R3: A rising edge on `start_in` loads exactly frame-size entries from consecutive SRAM addresses, but only when the block is idle and the scan count is nonzero. Each SRAM word carries the target register in bits 15:8 and the data in bits 7:0. The data is written to that holding register, and a later entry to the same target overwrites an earlier one.
- R4: A commit copies all 256 holding registers into the active registers on one clock edge.
- R5: `busy` stays high for exactly 8·N + 2 cycles per frame of N entries. Each entry uses ENTRY_CYC = 8 cycles and the closing interval uses TAIL_CYC = 2 cycles. The SRAM address stays constant for the whole time an entry is being fetched.
- R6: Bit 0 of the mode register (index 1) selects the commit source. When it is 1, the commit happens when the frame completes. When it is 0, the commit happens only on a rising edge of `update_in`.
- R7: A start edge that arrives while `busy` is high is ignored. It does not start a second frame and does not advance the frame index.
- R8: The scan count (index 4) decreases by one per completed frame. `done` is high whenever the scan count is zero. While the count is zero, start edges are ignored until the count is written again.
- R9: After reset, all holding and active registers read zero, `busy` is low and `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Control register write strobe |
| cpu_idx | input | 4 | Control register index |
| cpu_wdata | input | 16 | Control register write data |
| start_in | input | 1 | Frame start pulse |
| update_in | input | 1 | Commit pulse (used in pulse-commit mode) |
| sram_addr | output | 16 | SRAM read address |
| sram_rdata | input | 16 | SRAM read data, valid one cycle after the address |
| rd_addr | input | 8 | Register bank readback select |
| active_rd | output | 8 | Active register selected by `rd_addr` |
| hold_rd | output | 8 | Holding register selected by `rd_addr` |
| busy | output | 1 | Frame transfer in progress |
| done | output | 1 | Scan count exhausted |

## Verification
The hardest case to reach from the ports is a start edge that lands in the middle of a transfer. To show that it was dropped, the bench must prove that the frame index did not move. The bench raises a second start pulse a few cycles into a frame, then plays one more frame and checks that its contents come from the very next frame address rather than one frame further on. Pulse-driven commit is checked in a similar way. The bench compares the holding bank and the active bank after the frame, while they still differ, and then again after the update pulse.

// File: rtl/frs_pkg.sv
package frs_pkg;
  localparam int TGT_W = 8;
  localparam int VAL_W = 8;
  localparam int NUM_REGS = 1 << TGT_W;

  typedef struct packed {
    logic [TGT_W-1:0] tgt;
    logic [VAL_W-1:0] val;
  } entry_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_TAIL = 2'd2
  } seq_state_t;

  localparam logic [3:0] IDX_MODE  = 4'd1;
  localparam logic [3:0] IDX_FSIZE = 4'd2;
  localparam logic [3:0] IDX_SCAN  = 4'd4;
  localparam logic [3:0] IDX_BLOCK = 4'd8;
endpackage

// File: rtl/frs_ctrl_regs.sv
module frs_ctrl_regs
  import frs_pkg::*;
#(
  parameter int SRAM_AW = 16,
  parameter int SCAN_W  = 16,
  parameter int CPU_DW  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_we,
  input  logic [3:0]         cpu_idx,
  input  logic [CPU_DW-1:0]  cpu_wdata,
  input  logic               frame_done,
  output logic [SRAM_AW-1:0] blk_base,
  output logic [7:0]         fsize,
  output logic [SCAN_W-1:0]  scan_cnt,
  output logic               auto_mode,
  output logic [SRAM_AW-1:0] frame_idx
);
  logic [SRAM_AW-1:0] blk_d, idx_d;
  logic [7:0]         fsize_d;
  logic [SCAN_W-1:0]  scan_d;
  logic               auto_d;
  logic               wr_mode, wr_fsize, wr_scan, wr_blk;

  assign wr_mode  = cpu_we && (cpu_idx == IDX_MODE);
  assign wr_fsize = cpu_we && (cpu_idx == IDX_FSIZE);
  assign wr_scan  = cpu_we && (cpu_idx == IDX_SCAN);
  assign wr_blk   = cpu_we && (cpu_idx == IDX_BLOCK);

  always_comb begin
    auto_d  = auto_mode;
    fsize_d = fsize;
    blk_d   = blk_base;
    scan_d  = scan_cnt;
    idx_d   = frame_idx;
    if (wr_mode) auto_d = cpu_wdata[0];
    if (wr_fsize) begin
      if (cpu_wdata == '0)                    fsize_d = 8'd1;
      else if (cpu_wdata > CPU_DW'(255))      fsize_d = 8'd255;
      else                                    fsize_d = cpu_wdata[7:0];
    end
    if (wr_scan)                              scan_d = cpu_wdata[SCAN_W-1:0];
    else if (frame_done && scan_cnt != '0)    scan_d = scan_cnt - SCAN_W'(1);
    if (wr_blk) begin
      blk_d = cpu_wdata[SRAM_AW-1:0];
      idx_d = '0;
    end else if (frame_done) begin
      idx_d = frame_idx + SRAM_AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_mode <= 1'b1;
      fsize     <= 8'd1;
      blk_base  <= '0;
      scan_cnt  <= '0;
      frame_idx <= '0;
    end else begin
      auto_mode <= auto_d;
      fsize     <= fsize_d;
      blk_base  <= blk_d;
      scan_cnt  <= scan_d;
      frame_idx <= idx_d;
    end
  end
endmodule

// File: rtl/frs_timing.sv
module frs_timing
  import frs_pkg::*;
#(
  parameter int SRAM_AW   = 16,
  parameter int SCAN_W    = 16,
  parameter int ENTRY_CYC = 8,
  parameter int TAIL_CYC  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_in,
  input  logic               update_in,
  input  logic               auto_mode,
  input  logic [7:0]         fsize,
  input  logic [SCAN_W-1:0]  scan_cnt,
  input  logic [SRAM_AW-1:0] frame_base,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic               busy,
  output logic               hold_we,
  output logic               commit,
  output logic               frame_done
);
  localparam int MAXC = (ENTRY_CYC > TAIL_CYC) ? ENTRY_CYC : TAIL_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ENT_LAST  = CW'(ENTRY_CYC - 1);
  localparam logic [CW-1:0] TAIL_LAST = CW'(TAIL_CYC - 1);

  seq_state_t    st, st_d;
  logic [CW-1:0] cyc, cyc_d;
  logic [7:0]    ent, ent_d;
  logic          start_q, upd_q, start_edge, upd_edge;

  assign start_edge = start_in && !start_q;
  assign upd_edge   = update_in && !upd_q;

  always_comb begin
    st_d       = st;
    cyc_d      = cyc;
    ent_d      = ent;
    hold_we    = 1'b0;
    frame_done = 1'b0;
    case (st)
      ST_IDLE: begin
        if (start_edge && scan_cnt != '0) begin
          st_d  = ST_XFER;
          cyc_d = '0;
          ent_d = '0;
        end
      end
      ST_XFER: begin
        if (cyc == ENT_LAST) begin
          hold_we = 1'b1;
          cyc_d   = '0;
          if (ent == fsize - 8'd1) st_d = ST_TAIL;
          else                     ent_d = ent + 8'd1;
        end else begin
          cyc_d = cyc + CW'(1);
        end
      end
      ST_TAIL: begin
        if (cyc == TAIL_LAST) begin
          frame_done = 1'b1;
          st_d       = ST_IDLE;
          ent_d      = '0;
          cyc_d      = '0;
        end else begin
          cyc_d = cyc + CW'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign busy      = (st != ST_IDLE);
  assign commit    = auto_mode ? frame_done : upd_edge;
  assign sram_addr = frame_base + SRAM_AW'(ent);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cyc     <= '0;
      ent     <= '0;
      start_q <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      st      <= st_d;
      cyc     <= cyc_d;
      ent     <= ent_d;
      start_q <= start_in;
      upd_q   <= update_in;
    end
  end
endmodule

// File: rtl/frs_reg_banks.sv
module frs_reg_banks
  import frs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_we,
  input  entry_t           wr_entry,
  input  logic             commit,
  input  logic [TGT_W-1:0] rd_addr,
  output logic [VAL_W-1:0] active_rd,
  output logic [VAL_W-1:0] hold_rd
);
  logic [VAL_W-1:0] hold_q [NUM_REGS];
  logic [VAL_W-1:0] act_q  [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hold_en;
    assign hold_en = hold_we && (wr_entry.tgt == TGT_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hold_q[g] <= '0;
      else if (hold_en) hold_q[g] <= wr_entry.val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      act_q[g] <= '0;
      else if (commit) act_q[g] <= hold_q[g];
    end
  end

  assign active_rd = act_q[rd_addr];
  assign hold_rd   = hold_q[rd_addr];
endmodule

// File: rtl/frame_replay_seq.sv
module frame_replay_seq
  import frs_pkg::*;
#(
  parameter int SRAM_AW   = 16,
  parameter int SCAN_W    = 16,
  parameter int CPU_DW    = 16,
  parameter int ENTRY_CYC = 8,
  parameter int TAIL_CYC  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_we,
  input  logic [3:0]         cpu_idx,
  input  logic [CPU_DW-1:0]  cpu_wdata,
  input  logic               start_in,
  input  logic               update_in,
  output logic [SRAM_AW-1:0] sram_addr,
  input  logic [15:0]        sram_rdata,
  input  logic [7:0]         rd_addr,
  output logic [7:0]         active_rd,
  output logic [7:0]         hold_rd,
  output logic               busy,
  output logic               done
);
  logic [SRAM_AW-1:0] blk_base, frame_idx, frame_base;
  logic [7:0]         fsize;
  logic [SCAN_W-1:0]  scan_cnt;
  logic               auto_mode, hold_we, commit, frame_done;
  entry_t             wr_entry;

  assign frame_base = blk_base + SRAM_AW'(fsize) * frame_idx;
  assign wr_entry   = entry_t'(sram_rdata);
  assign done       = (scan_cnt == '0);

  frs_ctrl_regs #(.SRAM_AW(SRAM_AW), .SCAN_W(SCAN_W), .CPU_DW(CPU_DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_idx(cpu_idx),
    .cpu_wdata(cpu_wdata), .frame_done(frame_done), .blk_base(blk_base),
    .fsize(fsize), .scan_cnt(scan_cnt), .auto_mode(auto_mode),
    .frame_idx(frame_idx)
  );

  frs_timing #(.SRAM_AW(SRAM_AW), .SCAN_W(SCAN_W), .ENTRY_CYC(ENTRY_CYC),
               .TAIL_CYC(TAIL_CYC)) u_tim (
    .clk(clk), .rst_n(rst_n), .start_in(start_in), .update_in(update_in),
    .auto_mode(auto_mode), .fsize(fsize), .scan_cnt(scan_cnt),
    .frame_base(frame_base), .sram_addr(sram_addr), .busy(busy),
    .hold_we(hold_we), .commit(commit), .frame_done(frame_done)
  );

  frs_reg_banks u_banks (
    .clk(clk), .rst_n(rst_n), .hold_we(hold_we), .wr_entry(wr_entry),
    .commit(commit), .rd_addr(rd_addr), .active_rd(active_rd),
    .hold_rd(hold_rd)
  );
endmodule

// File: rtl/frs_checker.sv
module frs_checker #(
  parameter int SRAM_AW   = 16,
  parameter int SCAN_W    = 16,
  parameter int ENTRY_CYC = 8,
  parameter int TAIL_CYC  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               done,
  input logic               cpu_we,
  input logic               hold_we,
  input logic [7:0]         fsize,
  input logic [SCAN_W-1:0]  scan_cnt,
  input logic [SRAM_AW-1:0] sram_addr
);
  localparam int LEN_MAX = ENTRY_CYC * 255 + TAIL_CYC;
  int busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy_len <= 0;
    else if (busy)  busy_len <= busy_len + 1;
    else            busy_len <= 0;
  end

  // R1: the stored frame size is never zero
  a_r1_fsize_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    fsize != 8'd0);

  // R3: holding writes happen only inside a transfer
  a_r3_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    hold_we |-> busy);

  // R5: the SRAM address is steady while one entry is fetched
  a_r5_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(hold_we) && !$past(cpu_we)) |-> $stable(sram_addr));

  // R5: no transfer lasts longer than a maximal frame
  a_r5_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_len < LEN_MAX);

  // R8: an exhausted count keeps the block idle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !busy) |=> !busy);

  // R8: each finished frame uses up one scan
  a_r8_scan_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(cpu_we)) |-> scan_cnt == $past(scan_cnt) - SCAN_W'(1));
endmodule

bind frame_replay_seq frs_checker #(
  .SRAM_AW(SRAM_AW), .SCAN_W(SCAN_W), .ENTRY_CYC(ENTRY_CYC), .TAIL_CYC(TAIL_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .cpu_we(cpu_we),
  .hold_we(hold_we), .fsize(fsize), .scan_cnt(scan_cnt), .sram_addr(sram_addr)
);

// File: tb/frame_replay_seq_test.sv
module frame_replay_seq_test;
  logic        clk = 1'b0;
  logic        rst_n, cpu_we, start_in, update_in, busy, done;
  logic [3:0]  cpu_idx;
  logic [15:0] cpu_wdata, sram_addr, sram_rdata;
  logic [7:0]  rd_addr, active_rd, hold_rd;

  always #5 clk = ~clk;

  frame_replay_seq uut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_idx(cpu_idx),
    .cpu_wdata(cpu_wdata), .start_in(start_in), .update_in(update_in),
    .sram_addr(sram_addr), .sram_rdata(sram_rdata), .rd_addr(rd_addr),
    .active_rd(active_rd), .hold_rd(hold_rd), .busy(busy), .done(done)
  );

  logic [15:0] mem [1024];
  always_ff @(posedge clk) sram_rdata <= mem[sram_addr[9:0]];

  logic [7:0] hold_m [256];
  logic [7:0] act_m  [256];
  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    string req;
    int    kind;   // 0 = active bank, 1 = holding bank
    int    addr;
    int    exp;
  } item_t;
  item_t sbq[$];

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input string req, input int kind, input int addr, input int exp);
    item_t it;
    it.req = req; it.kind = kind; it.addr = addr; it.exp = exp;
    sbq.push_back(it);
  endtask

  // monitor: pops one expected item per cycle and compares the readback
  initial begin
    rd_addr = 8'd0;
    forever begin
      item_t it;
      int    act;
      @(negedge clk);
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        rd_addr = 8'(it.addr);
        #1;
        act = (it.kind == 0) ? int'(active_rd) : int'(hold_rd);
        n_cmp++;
        if (act != it.exp) begin
          n_bad++;
          $display("FAIL %s bank=%0d reg=%0d actual=%0d expected=%0d",
                   it.req, it.kind, it.addr, act, it.exp);
        end
      end
    end
  end

  task automatic drain();
    while (sbq.size() > 0) @(negedge clk);
    @(negedge clk);
    #2;
  endtask

  task automatic cpu_wr(input logic [3:0] idx, input int val);
    @(negedge clk);
    cpu_we = 1'b1; cpu_idx = idx; cpu_wdata = 16'(val);
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  // driver: one start pulse, measures busy, updates the model, queues expectations
  task automatic run_frame(input string req, input int base, input int fs,
                           input bit auto_c, input bit extra_start);
    int cnt = 0;
    @(negedge clk); start_in = 1'b1;
    @(negedge clk); start_in = 1'b0;
    chk({req, " R2 first SRAM address"}, int'(sram_addr), base);
    while (busy && cnt < 5000) begin
      cnt++;
      if (extra_start && cnt == 10) start_in = 1'b1;
      if (extra_start && cnt == 12) start_in = 1'b0;
      @(negedge clk);
    end
    chk({req, " R5 busy cycles"}, cnt, 8 * fs + 2);
    for (int i = 0; i < fs; i++) begin
      logic [15:0] e;
      e = mem[base + i];
      hold_m[e[15:8]] = e[7:0];
    end
    if (auto_c) for (int r = 0; r < 256; r++) act_m[r] = hold_m[r];
    for (int i = 0; i < fs; i++) begin
      logic [15:0] e;
      e = mem[base + i];
      push({req, " R3 holding"}, 1, int'(e[15:8]), int'(hold_m[e[15:8]]));
      push({req, " R4 active"}, 0, int'(e[15:8]), int'(act_m[e[15:8]]));
    end
    drain();
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = {8'(i * 37 + 5), 8'(i ^ 'h5A)};
    for (int r = 0; r < 256; r++) begin hold_m[r] = 8'd0; act_m[r] = 8'd0; end
    rst_n = 1'b0; cpu_we = 1'b0; cpu_idx = 4'd0; cpu_wdata = 16'd0;
    start_in = 1'b0; update_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk("R9 busy after reset", int'(busy), 0);
    chk("R9 done after reset", int'(done), 1);
    push("R9 active zero", 0, 8'h00, 0);
    push("R9 active zero", 0, 8'hFF, 0);
    push("R9 holding zero", 1, 8'h80, 0);
    drain();

    // R8 start ignored with zero count
    run_frame_ignored_check();

    // auto commit, three frames of six
    cpu_wr(4'd1, 1);
    cpu_wr(4'd2, 6);
    cpu_wr(4'd8, 100);
    cpu_wr(4'd4, 3);
    chk("R8 done low after count write", int'(done), 0);
    for (int k = 0; k < 3; k++) run_frame("R2 frame step", 100 + 6 * k, 6, 1'b1, 1'b0);
    chk("R8 done after last scan", int'(done), 1);
    @(negedge clk); start_in = 1'b1;
    @(negedge clk); start_in = 1'b0;
    chk("R8 start ignored when done", int'(busy), 0);

    // R7 extra start during a transfer; R2 index cleared by block write
    cpu_wr(4'd8, 200);
    cpu_wr(4'd4, 2);
    run_frame("R7 mid-frame start", 200, 6, 1'b1, 1'b1);
    repeat (4) @(negedge clk);
    chk("R7 no second frame", int'(busy), 0);
    run_frame("R7 next frame base", 206, 6, 1'b1, 1'b0);

    // R6 pulse-driven commit
    cpu_wr(4'd1, 0);
    cpu_wr(4'd2, 4);
    cpu_wr(4'd8, 300);
    cpu_wr(4'd4, 1);
    run_frame("R6 manual frame", 300, 4, 1'b0, 1'b0);
    @(negedge clk); update_in = 1'b1;
    @(negedge clk); update_in = 1'b0;
    for (int r = 0; r < 256; r++) act_m[r] = hold_m[r];
    for (int i = 0; i < 4; i++) begin
      logic [15:0] e;
      e = mem[300 + i];
      push("R6 commit on update", 0, int'(e[15:8]), int'(act_m[e[15:8]]));
    end
    push("R4 untouched reg", 0, 8'h01, int'(act_m[1]));
    drain();

    // R1 size zero becomes one; maximum size
    cpu_wr(4'd1, 1);
    cpu_wr(4'd2, 0);
    cpu_wr(4'd8, 400);
    cpu_wr(4'd4, 1);
    run_frame("R1 size zero", 400, 1, 1'b1, 1'b0);
    cpu_wr(4'd2, 300);
    cpu_wr(4'd8, 500);
    cpu_wr(4'd4, 1);
    run_frame("R1 size max", 500, 255, 1'b1, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic run_frame_ignored_check();
    @(negedge clk); start_in = 1'b1;
    @(negedge clk); start_in = 1'b0;
    chk("R8 start ignored at reset count", int'(busy), 0);
  endtask
endmodule